// File: doc/BRIEF.md
# Store-and-Forward Packet Receive Adapter

This block sits between an Ethernet MAC receive stream and a consumer that cannot tolerate bubbles inside a packet. The MAC side may drop its valid strobe for any number of cycles in the middle of a packet. The adapter writes every accepted beat into a first-word-fall-through buffer. It releases a packet downstream only after the packet's final beat is stored. The consumer therefore sees valid held high from the first beat of a packet to its last.

Each beat carries a data word, a byte-keep mask, an end-of-packet flag and a user flag that reports a receive error. A count of fully stored packets gates the output side. The input side never pushes back inside a packet, because a MAC cannot be stalled. Instead the adapter lowers its ready output between packets when the buffer is close to its high-water mark. A packet whose first beat arrives while ready is low is thrown away completely, up to and including its last beat.

The high-water mark and the longest legal packet are parameters. Their sum must not exceed the buffer depth, so that an accepted packet always fits.

Top module: `pkt_sf_rx_adapter`

## Requirements
- R1: Every accepted beat leaves the output unchanged and in arrival order. A buffer entry holds data in bits [DATA_W-1:0], keep above it, the end flag at bit DATA_W+KEEP_W and the user flag at bit DATA_W+KEEP_W+1 (bits 72 and 73 at the default width). The buffer never overflows.
- R2: Between packets, `in_ready` is high only while the stored-word level is below HIGH_MARK. Once the first beat of a packet is accepted, `in_ready` stays high until that packet's end beat is accepted.
- R3: If accepting an end beat leaves the level at HIGH_MARK or above, `in_ready` is low in the following cycle.
- R4: `out_valid` rises only when at least one complete packet is stored. With the output idle, it rises in the second cycle after the clock edge that accepted the packet's end beat.
- R5: A packet whose first beat arrives while `in_ready` is low is discarded, even if space frees up before its end beat. `in_ready` stays low until that end beat has passed, and the next packet may then be accepted.
- R6: Once raised, `out_valid` stays high until the end beat is taken (`out_valid`, `out_ready` and `out_last` all high). It is then low for at least one cycle.
- R7: A beat is removed only when `out_valid` and `out_ready` are both high. While `out_ready` is low, all output fields hold.
- R8: When a packet finishes storing and another finishes leaving on the same edge, the stored-packet count is unchanged. Every accepted packet is forwarded exactly once.
- R9: While `rst_n` is low, `in_ready` and `out_valid` are low. `in_ready` is high after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Receive data word |
| in_keep | input | DATA_W/8 | Receive byte-keep mask |
| in_last | input | 1 | End-of-packet marker for the receive beat |
| in_user | input | 1 | Receive error flag |
| in_valid | input | 1 | Receive beat present |
| in_ready | output | 1 | Adapter takes receive beats |
| out_data | output | DATA_W | Forwarded data word |
| out_keep | output | DATA_W/8 | Forwarded byte-keep mask |
| out_last | output | 1 | End-of-packet marker for the forwarded beat |
| out_user | output | 1 | Forwarded error flag |
| out_valid | output | 1 | Forwarded beat present |
| out_ready | input | 1 | Consumer takes the forwarded beat |

## Verification
Several input patterns are used. A single gap-free packet into an always-ready consumer isolates the store-then-release latency. Random packet lengths with random mid-packet gaps and a random consumer ready check that gaps never reach the output and that stalls hold the data. A scripted fill with the consumer stalled drives the level past the high-water mark. A packet then starts while ready is low and the consumer begins draining during it, which separates a correct drop from a packet that is half accepted. A stream of back-to-back one-beat packets forces stored and forwarded packet ends onto the same edges, and also triggers drops of single-beat packets.

// File: rtl/pkt_sf_pkg.sv
`timescale 1ns/1ps
package pkt_sf_pkg;

   // input-side packet tracking
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,   // between packets
      WS_BUSY = 2'd1,   // accepting a packet
      WS_DROP = 2'd2    // discarding a packet that started while not ready
   } wr_state_e;

   // output-side packet tracking
   typedef enum logic {
      RS_IDLE = 1'b0,
      RS_SEND = 1'b1
   } rd_state_e;

   // flag bits appended above data and keep in each buffer entry
   localparam int unsigned SF_FLAG_W = 2;

   function automatic int unsigned sf_entry_w(input int unsigned data_w);
      return data_w + data_w / 8 + SF_FLAG_W;
   endfunction

endpackage

// File: rtl/pkt_sf_fifo.sv
`timescale 1ns/1ps
module pkt_sf_fifo #(
   parameter int unsigned WIDTH = 74,
   parameter int unsigned DEPTH = 4096
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [WIDTH-1:0]                 wr_dat,
   input  logic                             rd_en,
   output logic [WIDTH-1:0]                 rd_dat,
   output logic [$clog2(DEPTH+1)-1:0]       level
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = $clog2(DEPTH + 1);
   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp, wp_inc, rp_inc;
   logic [LW-1:0]    cnt;

   // pointer advance: natural wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_pow2
         always_comb begin
            wp_inc = wp + 1'b1;
            rp_inc = rp + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            wp_inc = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            rp_inc = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_dat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_en) wp <= wp_inc;
         if (rd_en) rp <= rp_inc;
         cnt <= cnt + LW'(wr_en) - LW'(rd_en);
      end
   end

   // first word falls through: head entry is visible without a read strobe
   assign rd_dat = mem[rp];
   assign level  = cnt;

endmodule

// File: rtl/pkt_sf_wr_ctrl.sv
`timescale 1ns/1ps
module pkt_sf_wr_ctrl
   import pkt_sf_pkg::*;
#(
   parameter int unsigned DEPTH     = 4096,
   parameter int unsigned HIGH_MARK = 2944
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic                        in_last,
   input  logic [$clog2(DEPTH+1)-1:0]  level,
   input  logic                        pop,
   output logic                        in_ready,
   output logic                        wr_en,
   output wr_state_e                   state
);

   localparam int unsigned LW = $clog2(DEPTH + 1);

   wr_state_e     st, st_nx;
   logic          rdy_q, rdy_nx;
   logic [LW-1:0] lvl_nx;

   assign wr_en = in_valid & rdy_q;

   always_comb begin
      st_nx = st;
      case (st)
         WS_IDLE: begin
            if (in_valid && !in_last) st_nx = rdy_q ? WS_BUSY : WS_DROP;
         end
         WS_BUSY: begin
            if (in_valid && in_last) st_nx = WS_IDLE;
         end
         WS_DROP: begin
            if (in_valid && in_last) st_nx = WS_IDLE;
         end
         default: st_nx = WS_IDLE;
      endcase
   end

   // level as it stands after this edge, so the mark is judged on fresh data
   assign lvl_nx = level + LW'(wr_en) - LW'(pop);

   always_comb begin
      rdy_nx = 1'b0;
      if (st_nx == WS_BUSY)                               rdy_nx = 1'b1;
      else if (st_nx == WS_IDLE && lvl_nx < LW'(HIGH_MARK)) rdy_nx = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= WS_IDLE;
         rdy_q <= 1'b0;
      end else begin
         st    <= st_nx;
         rdy_q <= rdy_nx;
      end
   end

   assign in_ready = rdy_q;
   assign state    = st;

endmodule

// File: rtl/pkt_sf_rd_ctrl.sv
`timescale 1ns/1ps
module pkt_sf_rd_ctrl
   import pkt_sf_pkg::*;
#(
   parameter int unsigned DEPTH = 4096
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pkt_in,
   input  logic                        head_last,
   input  logic                        out_ready,
   output logic                        out_valid,
   output logic                        pop,
   output logic [$clog2(DEPTH+1)-1:0]  pkt_cnt
);

   localparam int unsigned LW = $clog2(DEPTH + 1);

   rd_state_e     st, st_nx;
   logic [LW-1:0] cnt_q;
   logic          done;

   assign pop  = (st == RS_SEND) & out_ready;
   assign done = pop & head_last;

   always_comb begin
      st_nx = st;
      case (st)
         RS_IDLE: if (cnt_q != '0) st_nx = RS_SEND;
         RS_SEND: if (done)        st_nx = RS_IDLE;
         default: st_nx = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= RS_IDLE;
         cnt_q <= '0;
      end else begin
         st    <= st_nx;
         // arrival and departure on one edge cancel
         cnt_q <= cnt_q + LW'(pkt_in) - LW'(done);
      end
   end

   assign out_valid = (st == RS_SEND);
   assign pkt_cnt   = cnt_q;

endmodule

// File: rtl/pkt_sf_rx_adapter.sv
`timescale 1ns/1ps
module pkt_sf_rx_adapter
   import pkt_sf_pkg::*;
#(
   parameter int unsigned DATA_W        = 64,
   parameter int unsigned DEPTH         = 4096,
   parameter int unsigned HIGH_MARK     = 2944,
   parameter int unsigned MAX_PKT_BEATS = 1152
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     in_data,
   input  logic [DATA_W/8-1:0]   in_keep,
   input  logic                  in_last,
   input  logic                  in_user,
   input  logic                  in_valid,
   output logic                  in_ready,
   output logic [DATA_W-1:0]     out_data,
   output logic [DATA_W/8-1:0]   out_keep,
   output logic                  out_last,
   output logic                  out_user,
   output logic                  out_valid,
   input  logic                  out_ready
);

   localparam int unsigned KEEP_W   = DATA_W / 8;
   localparam int unsigned ENT_W    = sf_entry_w(DATA_W);
   localparam int unsigned LAST_BIT = DATA_W + KEEP_W;
   localparam int unsigned USER_BIT = LAST_BIT + 1;
   localparam int unsigned LW       = $clog2(DEPTH + 1);

   generate
      if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_width
         $error("DATA_W must be a non-zero multiple of 8");
      end
      if (HIGH_MARK == 0 || HIGH_MARK > DEPTH) begin : g_bad_mark
         $error("HIGH_MARK must lie in 1..DEPTH");
      end
      if (HIGH_MARK + MAX_PKT_BEATS > DEPTH) begin : g_bad_room
         $error("HIGH_MARK + MAX_PKT_BEATS must not exceed DEPTH");
      end
   endgenerate

   logic [ENT_W-1:0] wr_ent, rd_ent;
   logic [LW-1:0]    fifo_lvl, pkt_cnt;
   logic             wr_en, pop;
   wr_state_e        wst;

   assign wr_ent = {in_user, in_last, in_keep, in_data};

   pkt_sf_wr_ctrl #(
      .DEPTH     (DEPTH),
      .HIGH_MARK (HIGH_MARK)
   ) wr_ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_last  (in_last),
      .level    (fifo_lvl),
      .pop      (pop),
      .in_ready (in_ready),
      .wr_en    (wr_en),
      .state    (wst)
   );

   pkt_sf_fifo #(
      .WIDTH (ENT_W),
      .DEPTH (DEPTH)
   ) fifo_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_dat (wr_ent),
      .rd_en  (pop),
      .rd_dat (rd_ent),
      .level  (fifo_lvl)
   );

   pkt_sf_rd_ctrl #(
      .DEPTH (DEPTH)
   ) rd_ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_in    (wr_en & in_last),
      .head_last (rd_ent[LAST_BIT]),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .pop       (pop),
      .pkt_cnt   (pkt_cnt)
   );

   assign out_data = rd_ent[DATA_W-1:0];
   assign out_keep = rd_ent[LAST_BIT-1:DATA_W];
   assign out_last = rd_ent[LAST_BIT];
   assign out_user = rd_ent[USER_BIT];

endmodule

// File: rtl/pkt_sf_rx_checker.sv
`timescale 1ns/1ps
module pkt_sf_rx_checker
   import pkt_sf_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned DEPTH     = 4096,
   parameter int unsigned HIGH_MARK = 2944
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic                        in_last,
   input logic                        in_ready,
   input logic [DATA_W-1:0]           out_data,
   input logic [DATA_W/8-1:0]         out_keep,
   input logic                        out_last,
   input logic                        out_user,
   input logic                        out_valid,
   input logic                        out_ready,
   input logic                        wr_en,
   input logic [$clog2(DEPTH+1)-1:0]  level,
   input logic [$clog2(DEPTH+1)-1:0]  pkt_cnt,
   input wr_state_e                   wst
);

   localparam int unsigned LW = $clog2(DEPTH + 1);

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && level == LW'(DEPTH)));

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> level != '0);

   assert_rise_below_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> level < LW'(HIGH_MARK));

   assert_ready_mid_packet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_last) |=> in_ready);

   assert_pause_at_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> (level < LW'(HIGH_MARK) || !in_ready));

   assert_release_needs_packet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(pkt_cnt) != '0);

   assert_drop_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wst == WS_DROP) |-> !wr_en);

   assert_valid_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(out_ready && out_last)) |=> out_valid);

   assert_gap_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);

   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_keep)
                                     && $stable(out_last) && $stable(out_user)));

   assert_count_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_last && out_valid && out_ready && out_last) |=> pkt_cnt == $past(pkt_cnt));

endmodule

bind pkt_sf_rx_adapter pkt_sf_rx_checker #(
   .DATA_W    (DATA_W),
   .DEPTH     (DEPTH),
   .HIGH_MARK (HIGH_MARK)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_last   (in_last),
   .in_ready  (in_ready),
   .out_data  (out_data),
   .out_keep  (out_keep),
   .out_last  (out_last),
   .out_user  (out_user),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .wr_en     (wr_en),
   .level     (fifo_lvl),
   .pkt_cnt   (pkt_cnt),
   .wst       (wst)
);

// File: tb/pkt_sf_rx_adapter_tb.sv
`timescale 1ns/1ps
module pkt_sf_rx_adapter_tb_top;

   localparam int unsigned DW    = 64;
   localparam int unsigned KW    = DW / 8;
   localparam int unsigned EW    = DW + KW + 2;
   localparam int unsigned DEP   = 32;
   localparam int unsigned HIGH  = 20;
   localparam int unsigned MAXB  = 8;
   localparam int          WDOG  = 50000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [DW-1:0] in_data;
   logic [KW-1:0] in_keep;
   logic          in_last, in_user, in_valid, in_ready;
   logic [DW-1:0] out_data;
   logic [KW-1:0] out_keep;
   logic          out_last, out_user, out_valid, out_ready;

   always #4 clk = ~clk;

   pkt_sf_rx_adapter #(
      .DATA_W        (DW),
      .DEPTH         (DEP),
      .HIGH_MARK     (HIGH),
      .MAX_PKT_BEATS (MAXB)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_keep   (in_keep),
      .in_last   (in_last),
      .in_user   (in_user),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .out_data  (out_data),
      .out_keep  (out_keep),
      .out_last  (out_last),
      .out_user  (out_user),
      .out_valid (out_valid),
      .out_ready (out_ready)
   );

   int n_chk = 0;
   int n_err = 0;
   bit run   = 0;
   int cyc   = 0;

   // reference model state
   bit            m_rdy = 0, m_vld = 0;
   int            m_wst = 0;        // 0 between packets, 1 accepting, 2 discarding
   int            m_pkts = 0;
   logic [EW-1:0] m_q[$];
   int            acc_cnt = 0;      // packets whose end beat was accepted
   int            rx_pkts = 0;      // packets whose end beat left the output

   // stimulus state
   int            len_q[$];
   int            g_rem = 0, g_beat = 0, g_id = 0;
   int            gap_pct = 0, ipg_pct = 0, ordy_pct = 0;
   bit            h_stall = 0;
   logic [EW-1:0] h_ent;

   task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   always @(negedge clk) begin
      if (run) begin
         logic [EW-1:0] cur;
         bit acc, pop, hl;
         int nw;
         bit nv, nr;
         cyc++;
         if (cyc > WDOG) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
         end
         cur = {out_user, out_last, out_keep, out_data};
         // compare outputs produced by the last edge
         chk(in_ready === m_rdy, "R2", EW'(in_ready), EW'(m_rdy));
         chk(out_valid === m_vld, "R6", EW'(out_valid), EW'(m_vld));
         if (m_vld) chk(cur === m_q[0], "R1", cur, m_q[0]);
         if (h_stall && out_valid) chk(cur === h_ent, "R7", cur, h_ent);

         // drive next input beat: first beat of a packet goes at once
         if (g_rem == 0 && len_q.size() > 0 && $urandom_range(99) >= ipg_pct) begin
            g_rem  = len_q.pop_front();
            g_beat = 0;
            g_id++;
            in_valid = 1'b1;
         end else begin
            in_valid = (g_rem > 0 && $urandom_range(99) >= gap_pct);
         end
         if (in_valid) begin
            in_last = (g_rem == 1);
            in_data = {32'(g_id), 32'(g_beat)};
            in_keep = in_last ? (8'hFF >> (g_id % 8)) : 8'hFF;
            in_user = in_last & g_id[0];
            g_rem--;
            g_beat++;
         end else begin
            in_last = 1'b0;
            in_user = 1'b0;
            in_keep = '0;
            in_data = '0;
         end
         out_ready = ($urandom_range(99) < ordy_pct);
         h_stall = out_valid && !out_ready;
         h_ent   = cur;
         if (out_valid && out_ready && out_last) rx_pkts++;

         // advance reference model to the coming edge
         acc = in_valid && m_rdy;
         pop = m_vld && out_ready;
         hl  = pop && m_q[0][DW+KW];
         nw  = m_wst;
         if (m_wst == 0) begin
            if (in_valid && !in_last) nw = m_rdy ? 1 : 2;
         end else if (in_valid && in_last) begin
            nw = 0;
         end
         nv = m_vld ? !hl : (m_pkts != 0);
         m_pkts = m_pkts + int'(acc && in_last) - int'(hl);
         if (pop) void'(m_q.pop_front());
         if (acc) begin
            m_q.push_back({in_user, in_last, in_keep, in_data});
            if (in_last) acc_cnt++;
         end
         nr = (nw == 1) || (nw == 0 && m_q.size() < HIGH);
         m_wst = nw;
         m_vld = nv;
         m_rdy = nr;
      end
   end

   task automatic wait_idle();
      while (!(len_q.size() == 0 && g_rem == 0 && m_q.size() == 0 && !m_vld))
         @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      int a0, r0;
      rst_n = 1'b0;
      in_valid = 1'b0; in_last = 1'b0; in_user = 1'b0;
      in_data = '0; in_keep = '0; out_ready = 1'b0;

      // R9: reset state
      repeat (3) @(posedge clk);
      #1;
      chk(in_ready === 1'b0 && out_valid === 1'b0, "R9",
          EW'({in_ready, out_valid}), EW'(0));
      rst_n = 1'b1;
      run   = 1'b1;
      @(posedge clk); #1;
      chk(in_ready === 1'b1, "R9", EW'(in_ready), EW'(1));

      // R4: single packet, release latency after the end beat
      gap_pct = 0; ipg_pct = 0; ordy_pct = 100;
      len_q.push_back(4);
      wait (acc_cnt == 1);
      @(posedge clk); #1;
      chk(out_valid === 1'b0, "R4", EW'(out_valid), EW'(0));
      @(posedge clk); #1;
      chk(out_valid === 1'b1, "R4", EW'(out_valid), EW'(1));
      wait_idle();

      // R1 R6 R7: random lengths, mid-packet gaps, random consumer stalls
      gap_pct = 40; ipg_pct = 30; ordy_pct = 60;
      for (int i = 0; i < 40; i++) len_q.push_back(1 + $urandom_range(MAXB - 1));
      wait_idle();

      // R3 R5: fill past the mark with the consumer stalled, then a dropped packet
      a0 = acc_cnt; r0 = rx_pkts;
      gap_pct = 0; ipg_pct = 0; ordy_pct = 0;
      len_q.push_back(8); len_q.push_back(8); len_q.push_back(8);
      len_q.push_back(8); len_q.push_back(5);
      wait (acc_cnt == a0 + 3);
      gap_pct = 70;                 // stretch the dropped packet while draining
      @(posedge clk); #1;
      chk(in_ready === 1'b0, "R3", EW'(in_ready), EW'(0));
      ordy_pct = 100;
      wait_idle();
      chk(rx_pkts - r0 == 4, "R5", EW'(rx_pkts - r0), EW'(4));
      chk(acc_cnt - a0 == 4, "R5", EW'(acc_cnt - a0), EW'(4));

      // R8: back-to-back one-beat packets, coinciding arrivals and departures
      gap_pct = 0; ipg_pct = 0; ordy_pct = 100;
      for (int i = 0; i < 40; i++) len_q.push_back((i % 5 == 4) ? 2 : 1);
      wait_idle();
      chk(rx_pkts == acc_cnt, "R8", EW'(rx_pkts), EW'(acc_cnt));
      chk(out_valid === 1'b0, "R8", EW'(out_valid), EW'(0));

      finish_run();
   end

endmodule